// File: doc/BRIEF.md
# Integer Multiply, Multiply-Accumulate and Divide Unit

This unit executes integer multiplies, multiply-accumulates and divides for a 64-bit processor pipeline. Each operation takes an opcode and two 64-bit operands. Its results land in a pair of 64-bit result registers, `hi` and `lo`, or for the direct-to-register multiply on a separate result port with a one-cycle valid strobe. For 32-bit multiplies the unit looks at the operands itself. When both fit in 16 bits the operation finishes sooner and can be re-issued sooner. A 64-bit multiply and both divide widths have fixed timing.

The pipeline offers an operation by raising `op_valid`. The unit accepts it on the first rising clock edge at which `issue_stall` is low. `issue_stall` stays high while the repeat interval of the previous operation has not elapsed, and the offered operation waits until it has. A read of the result registers is requested with `hilo_rd`. `rd_stall` holds that read off while an update of `hi`/`lo` is still in flight. After a direct-to-register multiply, `pipe_hold` marks the extra stall cycles the pipeline must insert.

Top module: `imac_div_unit`

## Requirements
- R1: After reset `hi`, `lo` and `gpr_result` are zero, and `gpr_valid`, `issue_stall`, `pipe_hold` and `rd_stall` are low.
- R2: For codes 0-4 (32-bit multiply group) an operand is short when it is signed and bits 31:15 are all equal, or unsigned and bits 31:16 are zero. With both operands short the latency is 3 and the repeat interval 2; otherwise they are 4 and 3.
- R3: The 64-bit multiplies have latency 6 and repeat interval 5 for any operand values; `hi` gets bits 127:64 and `lo` bits 63:0 of the 128-bit product.
- R4: The 32-bit divides take 36 cycles and the 64-bit divides 68 cycles, with a repeat interval equal to the latency. `lo` receives the quotient truncated toward zero and `hi` the remainder, which carries the sign of the dividend.
- R5: The direct-to-register multiply (code 4) drives `gpr_result` with the sign-extended low 32 bits of the signed product. `gpr_valid` is high for exactly one cycle, at the latency of R2. `hi` and `lo` are left unchanged.
- R6: After a code 4 issue, `pipe_hold` is high for 1 cycle with short operands and for 2 cycles otherwise.
- R7: Multiply-add (codes 2 signed, 3 unsigned) adds the 64-bit product to `{hi[31:0],lo[31:0]}` and writes the sum back split as in R9. Back-to-back multiply-adds each accumulate onto the previous sum.
- R8: `rd_stall` is high exactly while `hilo_rd` is high and a `hi`/`lo` update is pending. It falls in the cycle the new values become visible.
- R9: 32-bit multiplies and divides write `lo` with the sign-extension of the low 32-bit result word (product low half or quotient) and `hi` with the sign-extension of the high word (product high half or remainder).
- R10: Opcodes are 0 mult, 1 multu, 2 madd, 3 maddu, 4 direct mult, 5 dmult, 6 dmultu, 7 div, 8 divu, 9 ddiv, 10 ddivu. Codes 11-15 are ignored: they raise no `issue_stall` and do not change `hi`/`lo`.
- R11: `issue_stall` is high while `op_valid` offers a legal code before the repeat interval of the last accepted operation has elapsed. A held offer is accepted at the first edge where that interval has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is offered |
| op_code | input | 4 | Operation code (R10) |
| op_a | input | 64 | First operand / dividend |
| op_b | input | 64 | Second operand / divisor |
| issue_stall | output | 1 | Offered operation cannot issue this cycle |
| pipe_hold | output | 1 | Pipeline stall cycles after a direct-to-register multiply |
| hilo_rd | input | 1 | Pipeline wants to read hi/lo |
| rd_stall | output | 1 | The hi/lo read must wait |
| hi | output | 64 | HI result register |
| lo | output | 64 | LO result register |
| gpr_valid | output | 1 | One-cycle strobe for gpr_result |
| gpr_result | output | 64 | Result of the direct-to-register multiply |

## Verification
An operation is accepted at edge E. Its `hi`/`lo` update, or its `gpr_valid` strobe, is due right after edge E+L, where L is 3, 4, 6, 36 or 68 by operand class. The bench samples on the falling edge. It counts L-1 falling edges after acceptance and checks that the old value and a raised `rd_stall` are still present, then checks the new value one falling edge later. Repeat intervals are measured by offering a second operation straight away and counting the falling edges on which `issue_stall` is high, which must be one less than the interval. `pipe_hold` is sampled on the falling edges that follow acceptance.

// File: rtl/mdu_pkg.sv
// Package: shared opcodes, writeback kinds and arithmetic helpers of the
// multiply/divide unit. Assumes a 64-bit datapath with 32-bit half words.
package mdu_pkg;

    localparam int XW = 64;
    localparam int HW = 32;

    typedef enum logic [3:0] {
        OP_MULT   = 4'd0,
        OP_MULTU  = 4'd1,
        OP_MADD   = 4'd2,
        OP_MADDU  = 4'd3,
        OP_MULG   = 4'd4,
        OP_DMULT  = 4'd5,
        OP_DMULTU = 4'd6,
        OP_DIV    = 4'd7,
        OP_DIVU   = 4'd8,
        OP_DDIV   = 4'd9,
        OP_DDIVU  = 4'd10
    } mdu_op_e;

    typedef enum logic [1:0] {
        WB_HL32 = 2'd0,
        WB_ACC  = 2'd1,
        WB_HL64 = 2'd2,
        WB_GPR  = 2'd3
    } wb_kind_e;

    typedef struct packed {
        logic          vld;
        wb_kind_e      kind;
        logic [2*XW-1:0] prod;
    } wb_slot_t;

    // Sign-extend a half word to the full width.
    function automatic logic [XW-1:0] sx_half(input logic [HW-1:0] v);
        return {{(XW-HW){v[HW-1]}}, v};
    endfunction

    // Full-width product of the selected operand halves or words.
    function automatic logic [2*XW-1:0] mdu_product(input logic [XW-1:0] a,
                                                    input logic [XW-1:0] b,
                                                    input logic sgn,
                                                    input logic wide);
        logic [2*XW-1:0] xa, xb;
        if (wide) begin
            xa = sgn ? {{XW{a[XW-1]}}, a} : {{XW{1'b0}}, a};
            xb = sgn ? {{XW{b[XW-1]}}, b} : {{XW{1'b0}}, b};
        end else begin
            xa = sgn ? {{(2*XW-HW){a[HW-1]}}, a[HW-1:0]} : {{(2*XW-HW){1'b0}}, a[HW-1:0]};
            xb = sgn ? {{(2*XW-HW){b[HW-1]}}, b[HW-1:0]} : {{(2*XW-HW){1'b0}}, b[HW-1:0]};
        end
        return xa * xb;
    endfunction

endpackage

// File: rtl/mdu_size_detect.sv
// Operand size classifier: reports whether both operands of a half-word
// multiply fit the short class. Assumes SHORT_W < OP_W <= XW.
module mdu_size_detect #(
    parameter int OP_W    = 32,
    parameter int SHORT_W = 16
) (
    input  logic [63:0] a,
    input  logic [63:0] b,
    input  logic        sgn,
    output logic        both_short
);
    localparam int TOPN = OP_W - SHORT_W + 1;   // bits that must agree when signed

    logic [1:0] fits;
    logic [63:0] opnd [2];
    assign opnd[0] = a;
    assign opnd[1] = b;

    for (genvar i = 0; i < 2; i++) begin : g_opnd
        logic [TOPN-1:0] top;
        assign top = opnd[i][OP_W-1:SHORT_W-1];
        // per-operand fit test: sign bits all equal, or upper bits zero
        always_comb begin
            if (sgn) fits[i] = (top == '0) || (top == '1);
            else     fits[i] = (top[TOPN-1:1] == '0);
        end
    end

    assign both_short = &fits;
endmodule

// File: rtl/mdu_mul_line.sv
// Multiply retirement line: a product enters at the slot matching its
// latency and moves one slot per cycle toward slot 0, where it retires.
// Assumes in-order completion, so a loaded slot is never occupied.
module mdu_mul_line
    import mdu_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PW-1:0]   load_pos,
    input  wb_kind_e        load_kind,
    input  logic [2*XW-1:0] load_prod,
    output logic            ret_vld,
    output wb_kind_e        ret_kind,
    output logic [2*XW-1:0] ret_prod,
    output logic            hilo_pend
);
    wb_slot_t slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // slot update: load new entry, else take the one above, else empty
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i].vld  <= 1'b0;
                slot[i].kind <= WB_HL32;
                slot[i].prod <= '0;
            end else if (load && load_pos == PW'(i)) begin
                slot[i].vld  <= 1'b1;
                slot[i].kind <= load_kind;
                slot[i].prod <= load_prod;
            end else begin
                if (i < DEPTH - 1) slot[i] <= slot[(i < DEPTH - 1) ? i + 1 : i];
                else               slot[i].vld <= 1'b0;
            end
        end
    end

    assign ret_vld  = slot[0].vld;
    assign ret_kind = slot[0].kind;
    assign ret_prod = slot[0].prod;

    // pending flag: any live entry that will write hi/lo
    always_comb begin
        hilo_pend = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (slot[i].vld && slot[i].kind != WB_GPR) hilo_pend = 1'b1;
    end
endmodule

// File: rtl/mdu_div_seq.sv
// Sequential divider: one restoring step per cycle on operand magnitudes,
// result signs fixed at retirement, write strobe at a fixed latency.
// Assumes LAT_NARROW > HW and LAT_WIDE > XW; divide by zero is not handled.
module mdu_div_seq
    import mdu_pkg::*;
#(
    parameter int LAT_NARROW = 36,
    parameter int LAT_WIDE   = 68,
    localparam int CW        = $clog2(LAT_WIDE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          sgn,
    input  logic          wide,
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] b,
    output logic          busy,
    output logic          wr_en,
    output logic [XW-1:0] q_out,
    output logic [XW-1:0] r_out
);
    logic [XW:0]   rem;
    logic [XW-1:0] quo, dvs;
    logic [CW-1:0] cnt, steps;
    logic          neg_q, neg_r, wide_r;
    logic [HW-1:0] a32, b32;
    logic [XW-1:0] a64, b64;
    logic [XW:0]   shifted;

    // operand magnitudes for the signed forms
    always_comb begin
        a32 = (sgn && a[HW-1]) ? -a[HW-1:0] : a[HW-1:0];
        b32 = (sgn && b[HW-1]) ? -b[HW-1:0] : b[HW-1:0];
        a64 = (sgn && a[XW-1]) ? -a : a;
        b64 = (sgn && b[XW-1]) ? -b : b;
        shifted = {rem[XW-1:0], quo[XW-1]};
    end

    // iteration and latency countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0; quo <= '0; dvs <= '0;
            cnt <= '0; steps <= '0;
            neg_q <= 1'b0; neg_r <= 1'b0; wide_r <= 1'b0;
        end else if (start) begin
            rem    <= '0;
            quo    <= wide ? a64 : {a32, {HW{1'b0}}};
            dvs    <= wide ? b64 : {{HW{1'b0}}, b32};
            steps  <= wide ? CW'(XW) : CW'(HW);
            cnt    <= wide ? CW'(LAT_WIDE) : CW'(LAT_NARROW);
            wide_r <= wide;
            neg_r  <= sgn && (wide ? a[XW-1] : a[HW-1]);
            neg_q  <= sgn && ((wide ? a[XW-1] : a[HW-1]) ^ (wide ? b[XW-1] : b[HW-1]));
        end else begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            if (steps != '0) begin
                steps <= steps - 1'b1;
                if (shifted >= {1'b0, dvs}) begin
                    rem <= shifted - {1'b0, dvs};
                    quo <= {quo[XW-2:0], 1'b1};
                end else begin
                    rem <= shifted;
                    quo <= {quo[XW-2:0], 1'b0};
                end
            end
        end
    end

    assign busy  = (cnt != '0);
    assign wr_en = (cnt == CW'(1));

    // sign correction and half-word sign extension of the results
    always_comb begin
        if (wide_r) begin
            q_out = neg_q ? -quo : quo;
            r_out = neg_r ? -rem[XW-1:0] : rem[XW-1:0];
        end else begin
            q_out = sx_half(neg_q ? -quo[HW-1:0] : quo[HW-1:0]);
            r_out = sx_half(neg_r ? -rem[HW-1:0] : rem[HW-1:0]);
        end
    end
endmodule

// File: rtl/imac_div_unit.sv
// Top of the integer multiply / multiply-add / divide unit. Decodes the
// opcode, picks latency and repeat interval, keeps the issue interlock and
// owns hi/lo and the direct-result port. Assumes multiply latency equals
// repeat interval plus one, which keeps completions in issue order.
module imac_div_unit
    import mdu_pkg::*;
#(
    parameter int MUL16_LAT  = 3,
    parameter int MUL32_LAT  = 4,
    parameter int DMUL_LAT   = 6,
    parameter int DIV32_LAT  = 36,
    parameter int DIV64_LAT  = 68,
    parameter int HOLD_SHORT = 1,
    parameter int HOLD_LONG  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [63:0]   op_a,
    input  logic [63:0]   op_b,
    output logic          issue_stall,
    output logic          pipe_hold,
    input  logic          hilo_rd,
    output logic          rd_stall,
    output logic [63:0]   hi,
    output logic [63:0]   lo,
    output logic          gpr_valid,
    output logic [63:0]   gpr_result
);
    localparam int CW = $clog2(DIV64_LAT + 1);
    localparam int PW = $clog2(DMUL_LAT);
    localparam int HCW = $clog2(HOLD_LONG + 1);

    logic          legal, sgn, is_m32, is_m64, is_d32, is_d64, is_div, short_ops;
    logic          issue_fire;
    logic [CW-1:0] op_lat, op_rep, rep_cnt;
    logic [HCW-1:0] hold_cnt;
    wb_kind_e      kind;
    logic          ret_vld, line_pend, div_busy, div_wr;
    wb_kind_e      ret_kind;
    logic [2*XW-1:0] ret_prod;
    logic [XW-1:0] div_q, div_r, acc_sum;

    // opcode decode
    always_comb begin
        legal  = (op_code <= OP_DDIVU);
        is_m32 = (op_code <= OP_MULG);
        is_m64 = (op_code == OP_DMULT) || (op_code == OP_DMULTU);
        is_d32 = (op_code == OP_DIV)   || (op_code == OP_DIVU);
        is_d64 = (op_code == OP_DDIV)  || (op_code == OP_DDIVU);
        is_div = is_d32 || is_d64;
        sgn    = (op_code == OP_MULT) || (op_code == OP_MADD) || (op_code == OP_MULG) ||
                 (op_code == OP_DMULT) || (op_code == OP_DIV) || (op_code == OP_DDIV);
        case (op_code)
            OP_MADD, OP_MADDU:    kind = WB_ACC;
            OP_MULG:              kind = WB_GPR;
            OP_DMULT, OP_DMULTU:  kind = WB_HL64;
            default:              kind = WB_HL32;
        endcase
    end

    mdu_size_detect #(.OP_W(HW), .SHORT_W(16)) u_size (
        .a(op_a), .b(op_b), .sgn(sgn), .both_short(short_ops)
    );

    // latency and repeat interval of the offered operation
    always_comb begin
        if (is_m32)      op_lat = short_ops ? CW'(MUL16_LAT) : CW'(MUL32_LAT);
        else if (is_m64) op_lat = CW'(DMUL_LAT);
        else if (is_d32) op_lat = CW'(DIV32_LAT);
        else             op_lat = CW'(DIV64_LAT);
        op_rep = is_div ? op_lat : op_lat - 1'b1;
    end

    assign issue_fire  = op_valid && legal && (rep_cnt == '0);
    assign issue_stall = op_valid && legal && (rep_cnt != '0);

    // repeat-interval and direct-multiply hold counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_cnt  <= '0;
            hold_cnt <= '0;
        end else begin
            if (issue_fire)          rep_cnt <= op_rep - 1'b1;
            else if (rep_cnt != '0)  rep_cnt <= rep_cnt - 1'b1;
            if (issue_fire && op_code == OP_MULG)
                hold_cnt <= short_ops ? HCW'(HOLD_SHORT) : HCW'(HOLD_LONG);
            else if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end
    assign pipe_hold = (hold_cnt != '0);

    mdu_mul_line #(.DEPTH(DMUL_LAT)) u_line (
        .clk(clk), .rst_n(rst_n),
        .load(issue_fire && !is_div),
        .load_pos(PW'(op_lat - 1'b1)),
        .load_kind(kind),
        .load_prod(mdu_product(op_a, op_b, sgn, is_m64)),
        .ret_vld(ret_vld), .ret_kind(ret_kind), .ret_prod(ret_prod),
        .hilo_pend(line_pend)
    );

    mdu_div_seq #(.LAT_NARROW(DIV32_LAT), .LAT_WIDE(DIV64_LAT)) u_div (
        .clk(clk), .rst_n(rst_n),
        .start(issue_fire && is_div), .sgn(sgn), .wide(is_d64),
        .a(op_a), .b(op_b),
        .busy(div_busy), .wr_en(div_wr), .q_out(div_q), .r_out(div_r)
    );

    assign rd_stall = hilo_rd && (line_pend || div_busy);
    assign acc_sum  = {hi[HW-1:0], lo[HW-1:0]} + ret_prod[XW-1:0];

    // hi/lo and direct-result writeback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= '0; lo <= '0;
            gpr_valid <= 1'b0; gpr_result <= '0;
        end else begin
            gpr_valid <= ret_vld && (ret_kind == WB_GPR);
            if (ret_vld) begin
                case (ret_kind)
                    WB_HL32: begin hi <= sx_half(ret_prod[63:32]); lo <= sx_half(ret_prod[31:0]); end
                    WB_ACC:  begin hi <= sx_half(acc_sum[63:32]);  lo <= sx_half(acc_sum[31:0]);  end
                    WB_HL64: begin hi <= ret_prod[127:64];         lo <= ret_prod[63:0];          end
                    default: gpr_result <= sx_half(ret_prod[31:0]);
                endcase
            end else if (div_wr) begin
                hi <= div_r;
                lo <= div_q;
            end
        end
    end
endmodule

// File: rtl/imac_div_unit_chk.sv
// Checker for imac_div_unit: protocol properties over its ports and the
// internal issue strobe. Attached by the bind statement at the end.
module imac_div_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic        issue_fire,
    input logic        issue_stall,
    input logic        hilo_rd,
    input logic        rd_stall,
    input logic        pipe_hold,
    input logic        gpr_valid,
    input logic [63:0] hi,
    input logic [63:0] lo
);
    logic [2:0] hold_run;

    // length of the current run of pipe_hold cycles
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_run <= '0;
        else if (pipe_hold) hold_run <= (hold_run == 3'd7) ? hold_run : hold_run + 1'b1;
        else                hold_run <= '0;
    end

    AST_STALL_NOT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stall |-> (op_valid && !issue_fire)); // R11
    AST_ISSUE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |=> !issue_fire); // R2
    AST_RD_STALL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall |-> hilo_rd); // R8
    AST_GPR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_valid |=> !gpr_valid); // R5
    AST_GPR_KEEPS_HILO: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_valid |-> ($stable(hi) && $stable(lo))); // R5
    AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        hold_run <= 3'd2); // R6
endmodule

bind imac_div_unit imac_div_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .issue_fire(issue_fire),
    .issue_stall(issue_stall), .hilo_rd(hilo_rd), .rd_stall(rd_stall),
    .pipe_hold(pipe_hold), .gpr_valid(gpr_valid), .hi(hi), .lo(lo)
);

// File: tb/imac_div_unit_bench.sv
// Bench for imac_div_unit: directed timing checks plus seeded random
// operations compared with a behavioural model of hi/lo and the result port.
module imac_div_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        op_valid = 1'b0, hilo_rd = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        issue_stall, pipe_hold, rd_stall, gpr_valid;
    logic [63:0] hi, lo, gpr_result;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [63:0] m_hi = '0, m_lo = '0, m_gpr = '0;

    imac_div_unit u_imac_div_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_a(op_a), .op_b(op_b), .issue_stall(issue_stall), .pipe_hold(pipe_hold),
        .hilo_rd(hilo_rd), .rd_stall(rd_stall), .hi(hi), .lo(lo),
        .gpr_valid(gpr_valid), .gpr_result(gpr_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    // behavioural model of one operation on the bench's hi/lo copy
    task automatic model(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        logic signed [63:0] sp, sa, sb;
        logic [63:0] up, s;
        logic signed [127:0] wp;
        logic [127:0] uw;
        logic signed [31:0] q32, r32;
        logic signed [63:0] q64, r64;
        sa = sx(a[31:0]); sb = sx(b[31:0]);
        sp = sa * sb;
        up = {32'b0, a[31:0]} * {32'b0, b[31:0]};
        case (op)
            4'd0: begin m_hi = sx(sp[63:32]); m_lo = sx(sp[31:0]); end
            4'd1: begin m_hi = sx(up[63:32]); m_lo = sx(up[31:0]); end
            4'd2: begin s = {m_hi[31:0], m_lo[31:0]} + sp; m_hi = sx(s[63:32]); m_lo = sx(s[31:0]); end
            4'd3: begin s = {m_hi[31:0], m_lo[31:0]} + up; m_hi = sx(s[63:32]); m_lo = sx(s[31:0]); end
            4'd4: m_gpr = sx(sp[31:0]);
            4'd5: begin wp = $signed(a) * $signed(b); m_hi = wp[127:64]; m_lo = wp[63:0]; end
            4'd6: begin uw = {64'b0, a} * {64'b0, b}; m_hi = uw[127:64]; m_lo = uw[63:0]; end
            4'd7: begin q32 = $signed(a[31:0]) / $signed(b[31:0]); r32 = $signed(a[31:0]) % $signed(b[31:0]);
                        m_lo = sx(q32); m_hi = sx(r32); end
            4'd8: begin m_lo = sx(a[31:0] / b[31:0]); m_hi = sx(a[31:0] % b[31:0]); end
            4'd9: begin q64 = $signed(a) / $signed(b); r64 = $signed(a) % $signed(b); m_lo = q64; m_hi = r64; end
            4'd10: begin m_lo = a / b; m_hi = a % b; end
            default: ;
        endcase
    endtask

    // offer an operation from a falling edge; return at the falling edge
    // after the accepting rising edge, with the number of stalled samples
    task automatic present(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b, output int stalls);
        op_valid = 1'b1; op_code = op; op_a = a; op_b = b; stalls = 0;
        #1;
        while (issue_stall) begin
            stalls++;
            @(negedge clk); #1;
        end
        @(negedge clk);
        op_valid = 1'b0;
        #1;
    endtask

    // read hi/lo through the interlock and compare with the model
    task automatic read_hilo(input string tag);
        hilo_rd = 1'b1; #1;
        for (int i = 0; i < 100 && rd_stall; i++) begin @(negedge clk); #1; end
        chk(hi == m_hi, {tag, " hi"}, hi, m_hi);
        chk(lo == m_lo, {tag, " lo"}, lo, m_lo);
        hilo_rd = 1'b0;
    endtask

    task automatic wait_gpr(input string tag);
        for (int i = 0; i < 10 && !gpr_valid; i++) begin @(negedge clk); #1; end
        chk(gpr_valid === 1'b1, {tag, " gpr_valid"}, 64'(gpr_valid), 64'd1);
        chk(gpr_result == m_gpr, {tag, " gpr_result"}, gpr_result, m_gpr);
    endtask

    // exact-latency check: old value and stall at L-1, new value at L
    task automatic lat_test(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                            input int lat, input string tag);
        logic [63:0] oh, ol;
        int s;
        oh = m_hi; ol = m_lo;
        model(op, a, b);
        present(op, a, b, s);
        hilo_rd = 1'b1;
        repeat (lat - 1) @(negedge clk);
        #1;
        if (op == 4'd4) begin
            chk(gpr_valid == 1'b0, {tag, " gpr early"}, 64'(gpr_valid), 64'd0);
        end else begin
            chk(rd_stall == 1'b1, {tag, " rd_stall before due"}, 64'(rd_stall), 64'd1);
            chk(hi == oh && lo == ol, {tag, " hi/lo held before due"}, lo, ol);
        end
        @(negedge clk); #1;
        if (op == 4'd4) begin
            chk(gpr_valid == 1'b1 && gpr_result == m_gpr, {tag, " gpr at latency"}, gpr_result, m_gpr);
            chk(hi == m_hi && lo == m_lo, {tag, " hi/lo untouched"}, lo, m_lo);
        end else begin
            chk(rd_stall == 1'b0, {tag, " rd_stall released"}, 64'(rd_stall), 64'd0);
            chk(hi == m_hi, {tag, " hi at latency"}, hi, m_hi);
            chk(lo == m_lo, {tag, " lo at latency"}, lo, m_lo);
        end
        hilo_rd = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // repeat-interval check: a second identical op stalls rep-1 samples
    task automatic rep_test(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                            input int rep, input string tag);
        int s1, s2;
        model(op, a, b);
        present(op, a, b, s1);
        present(op, a, b, s2);
        chk(s2 == rep - 1, {tag, " repeat stalls"}, 64'(s2), 64'(rep - 1));
        if (op == 4'd4) wait_gpr(tag);
        else            read_hilo(tag);
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [63:0] rnd_opnd();
        case ($urandom % 4)
            0: return sx({{16{1'b0}}, 16'($urandom)}) ^ (($urandom % 2) ? 64'hFFFF_FFFF_FFFF_8000 : 64'h0);
            1: return {32'($urandom), 32'($urandom)};
            2: return sx(32'($urandom));
            default: return 64'($urandom % 8) - 64'd4;
        endcase
    endfunction

    initial begin
        int s;
        void'($urandom(32'h5EED_1234));
        hilo_rd = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(hi == 0 && lo == 0, "R1 hi/lo reset", lo, 0);
        chk(gpr_result == 0 && !gpr_valid, "R1 gpr reset", gpr_result, 0);
        chk(!issue_stall && !pipe_hold && !rd_stall, "R1 stalls low", 64'({issue_stall, pipe_hold, rd_stall}), 0);
        rst_n = 1'b1;
        hilo_rd = 1'b0;
        @(negedge clk);

        // R2 / R9: size classes and latencies
        lat_test(4'd0, 64'd1234, 64'hFFFF_FFFF_FFFF_8000, 3, "R2 signed short");
        lat_test(4'd0, 64'h0000_8000, 64'd3, 4, "R2 signed 0x8000 long");
        lat_test(4'd1, 64'h0000_FFFF, 64'h0000_FFFF, 3, "R2 unsigned short");
        lat_test(4'd1, 64'h0001_0000, 64'd5, 4, "R2 unsigned long");
        lat_test(4'd0, 64'h8765_4321, 64'h1234_5678, 4, "R9 signed split");
        // R3: 64-bit multiply
        lat_test(4'd5, 64'hFFFF_FFFF_FFFF_FFFD, 64'h0123_4567_89AB_CDEF, 6, "R3 dmult");
        lat_test(4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6, "R3 dmultu");
        // R4: divides with negative operands
        lat_test(4'd7, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, 36, "R4 div");
        lat_test(4'd8, 64'h0000_0000_FFFF_FFF9, 64'd2, 36, "R4 divu");
        lat_test(4'd9, 64'd100, 64'hFFFF_FFFF_FFFF_FFF9, 68, "R4 ddiv");
        lat_test(4'd10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd10, 68, "R4 ddivu");
        // R5: direct-to-register multiply
        lat_test(4'd4, 64'hFFFF_FFFF_FFFF_FFF0, 64'd7, 3, "R5 mulg short");
        lat_test(4'd4, 64'h0012_3456, 64'h0000_7000, 4, "R5 mulg long");

        // R11 / R2 / R3 / R4: repeat intervals
        rep_test(4'd0, 64'd3, 64'd4, 2, "R11 R2 mult short");
        rep_test(4'd0, 64'h0010_0000, 64'd4, 3, "R11 R2 mult long");
        rep_test(4'd5, 64'd9, 64'd9, 5, "R11 R3 dmult");
        rep_test(4'd7, 64'd1000, 64'd7, 36, "R11 R4 div");
        rep_test(4'd4, 64'h0010_0000, 64'd4, 3, "R11 R5 mulg");

        // R6: pipe_hold lengths
        model(4'd4, 64'd5, 64'd6);
        present(4'd4, 64'd5, 64'd6, s);
        chk(pipe_hold == 1'b1, "R6 short hold cycle 1", 64'(pipe_hold), 1);
        @(negedge clk); #1;
        chk(pipe_hold == 1'b0, "R6 short hold ends", 64'(pipe_hold), 0);
        wait_gpr("R6 short");
        repeat (4) @(negedge clk);
        model(4'd4, 64'h0100_0000, 64'd6);
        present(4'd4, 64'h0100_0000, 64'd6, s);
        chk(pipe_hold == 1'b1, "R6 long hold cycle 1", 64'(pipe_hold), 1);
        @(negedge clk); #1;
        chk(pipe_hold == 1'b1, "R6 long hold cycle 2", 64'(pipe_hold), 1);
        @(negedge clk); #1;
        chk(pipe_hold == 1'b0, "R6 long hold ends", 64'(pipe_hold), 0);
        wait_gpr("R6 long");
        repeat (4) @(negedge clk);

        // R7: back-to-back multiply-adds
        model(4'd0, 64'h7FFF_FFFF, 64'h7FFF_FFFF);
        present(4'd0, 64'h7FFF_FFFF, 64'h7FFF_FFFF, s);
        for (int k = 0; k < 3; k++) begin
            model(4'd2, 64'h4000_0000 + 64'(k), 64'hFFFF_FFFF_F000_0000);
            present(4'd2, 64'h4000_0000 + 64'(k), 64'hFFFF_FFFF_F000_0000, s);
        end
        model(4'd3, 64'hFFFF_FFFF, 64'h0000_0003);
        present(4'd3, 64'hFFFF_FFFF, 64'h0000_0003, s);
        read_hilo("R7 madd chain");

        // R10: illegal codes ignored, even while a divide runs
        model(4'd9, 64'd77777, 64'd13);
        present(4'd9, 64'd77777, 64'd13, s);
        for (int c = 11; c < 16; c++) begin
            op_valid = 1'b1; op_code = 4'(c); op_a = 64'd3; op_b = 64'd3;
            #1;
            chk(issue_stall == 1'b0, "R10 no stall on unused code", 64'(issue_stall), 0);
            @(negedge clk);
        end
        op_valid = 1'b0;
        read_hilo("R10 hi/lo after unused codes");
        for (int c = 11; c < 16; c++) begin
            op_valid = 1'b1; op_code = 4'(c);
            @(negedge clk);
        end
        op_valid = 1'b0;
        hilo_rd = 1'b1;
        repeat (8) @(negedge clk);
        #1;
        chk(rd_stall == 1'b0, "R10 R8 no pending update", 64'(rd_stall), 0);
        chk(hi == m_hi && lo == m_lo, "R10 hi/lo unchanged", lo, m_lo);
        hilo_rd = 1'b0;

        // random mix, all codes, model comparison
        for (int n = 0; n < 250; n++) begin
            logic [3:0] op;
            logic [63:0] a, b;
            op = 4'($urandom % 11);
            a = rnd_opnd();
            b = rnd_opnd();
            if (op == 4'd7 || op == 4'd8) begin
                if (b[31:0] == 0) b = 64'd7;
                if (op == 4'd7 && b[31:0] == 32'hFFFF_FFFF) b = 64'd3;
            end
            if (op == 4'd9 || op == 4'd10) begin
                if (b == 0) b = 64'd7;
                if (op == 4'd9 && b == '1) b = 64'd3;
            end
            model(op, a, b);
            present(op, a, b, s);
            if (op == 4'd4) wait_gpr("R5 random mulg");
            else if (op <= 4'd3) read_hilo("R2 R7 R9 random mul32");
            else if (op <= 4'd6) read_hilo("R3 random mul64");
            else read_hilo("R4 random div");
            if (n % 7 == 0) repeat (70) @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule